// File: doc/BRIEF.md
# Effective Address Generator with Pointer Chasing

This block turns an instruction's memory-operand description into the final operand address, or into the operand itself for immediate and register modes. A single-cycle `start` pulse presents a 4-bit mode, two register selectors, a displacement, a 2-bit scale and a 2-bit operand size. The block reads up to two registers through an asynchronous register-file read port. It forms the address from those values and reports the result with a one-cycle `done` pulse.

Auto-modify modes step the selected register by the operand size. The updated register value goes out through the register write port in the same cycle as `done`. Indirect modes issue word reads on a request/response memory port and wait for each response. In the multi-level mode, each fetched word's top bit marks the last pointer of the chain. A run of eight pointers with no final marker ends with an error flag, so the walk never loops forever.

Top module: `ea_gen`

## Requirements
- R1: While reset is high and after it is released, `done`, `done_err`, `rf_we` and `mem_req` are low until a `start` is accepted.
- R2: Mode 0 (immediate) returns `disp` as the value. Codes 13 to 15 behave like mode 0. With no memory request and no register write, `done` is high in the cycle that follows the edge after the one that sampled `start`. This one-cycle calculation latency holds for every mode that does not fetch.
- R3: Mode 1 (register) returns the value of the register picked by `base_sel`.
- R4: Mode 2 (absolute) returns `disp`. Mode 3 (register indirect) returns the register picked by `base_sel`.
- R5: Mode 4 returns base+disp. Mode 5 returns (index << scale)+disp. Mode 6 returns (index << scale)+base+disp. Base is the register picked by `base_sel`, index is the register picked by `idx_sel`, and the sums wrap modulo 2^AW.
- R6: Mode 7 (pre-increment) and mode 8 (pre-decrement) return base ± step, where step = 1 << `osize` (1, 2, 4 or 8 words).
- R7: Mode 9 (post-increment) and mode 10 (post-decrement) return the unmodified base. The value written back is base ± step.
- R8: In modes 7 to 10 only, `rf_we` is high for exactly the `done` cycle. It writes the stepped value to register `base_sel`, so a later register-mode read returns that value.
- R9: Mode 11 (double indirect) makes exactly one read at the base register value. It returns the fetched word unchanged, top bit included.
- R10: Mode 12 (multi-level indirect) first reads at the base register value. Each fetched word with bit AW-1 clear is masked and used as the next read address. The first word with bit AW-1 set ends the walk, and its low AW-1 bits, with bit AW-1 cleared, are returned.
- R11: Each read waits for `mem_rvalid` with one request outstanding at most. A walk of n pointers with response latency L gives `done` 1+n·(L+2) cycles after the cycle following the start edge.
- R12: In mode 12, if the eighth fetched word still has bit AW-1 clear, the walk stops after exactly 8 reads and returns `done_err`=1 with value 0. A marker on the eighth word is not an error.
- R13: A `start` arriving while an operation is in progress is ignored. Each accepted operation yields exactly one one-cycle `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request, accepted when idle |
| mode | input | 4 | Addressing mode code |
| base_sel | input | RW | Base register selector, also the writeback target |
| idx_sel | input | RW | Index register selector |
| disp | input | AW | Displacement or immediate constant |
| scale | input | 2 | Index shift amount (×1, ×2, ×4, ×8) |
| osize | input | 2 | Operand size code, step = 1 << osize words |
| rf_rd_a_idx | output | RW | Register read port A selector (base) |
| rf_rd_a_data | input | AW | Register read port A data, same cycle |
| rf_rd_b_idx | output | RW | Register read port B selector (index) |
| rf_rd_b_data | input | AW | Register read port B data, same cycle |
| rf_we | output | 1 | Register writeback strobe |
| rf_wr_idx | output | RW | Writeback register selector |
| rf_wr_data | output | AW | Writeback value |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | AW | Memory response word |
| done | output | 1 | One-cycle result strobe |
| done_value | output | AW | Final address or operand value |
| done_err | output | 1 | Indirection limit exceeded |

## Verification
The arithmetic modes are swept over every base/index register pair and every scale, using register contents chosen so that each sum differs. This shows whether the two selectors, the shift and the displacement are wired correctly. The auto-modify modes are swept over every register and every size, so a pre/post swap or a wrong step shows up in the returned value and in the writeback. Pointer chains of lengths 1 to 9 are walked at several response latencies. Exact latency and request counts tell a correct walk apart from extra requests, premature ends and a misplaced cap. A start injected mid-walk shows whether busy-time requests are ignored.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_REG  = 4'd1,
    M_ABS  = 4'd2,
    M_IND  = 4'd3,
    M_IDX  = 4'd4,
    M_SCL  = 4'd5,
    M_CMB  = 4'd6,
    M_PREI = 4'd7,
    M_PRED = 4'd8,
    M_POSI = 4'd9,
    M_POSD = 4'd10,
    M_DIND = 4'd11,
    M_MIND = 4'd12
  } ea_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CALC = 2'd1,
    S_WAIT = 2'd2
  } ea_state_e;

endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_gen_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [AW-1:0] disp,
  input  logic [1:0]    scale,
  input  logic [1:0]    osize,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val,
  output logic          wb_en,
  output logic          fetch
);

  logic [AW-1:0] step;
  logic [AW-1:0] scaled;
  logic [AW-1:0] stepped_up;
  logic [AW-1:0] stepped_dn;

  assign step       = AW'(1) << osize;
  assign scaled     = rb << scale;
  assign stepped_up = ra + step;
  assign stepped_dn = ra - step;

  always_comb begin
    addr   = disp;
    wb_val = ra;
    wb_en  = 1'b0;
    fetch  = 1'b0;
    case (ea_mode_e'(mode))
      M_REG:  addr = ra;
      M_ABS:  addr = disp;
      M_IND:  addr = ra;
      M_IDX:  addr = ra + disp;
      M_SCL:  addr = scaled + disp;
      M_CMB:  addr = scaled + ra + disp;
      M_PREI: begin addr = stepped_up; wb_val = stepped_up; wb_en = 1'b1; end
      M_PRED: begin addr = stepped_dn; wb_val = stepped_dn; wb_en = 1'b1; end
      M_POSI: begin addr = ra;         wb_val = stepped_up; wb_en = 1'b1; end
      M_POSD: begin addr = ra;         wb_val = stepped_dn; wb_en = 1'b1; end
      M_DIND: begin addr = ra; fetch = 1'b1; end
      M_MIND: begin addr = ra; fetch = 1'b1; end
      default: addr = disp;
    endcase
  end

endmodule

// File: rtl/ea_ptr_chain.sv
module ea_ptr_chain #(
  parameter int AW         = 16,
  parameter int MAX_LEVELS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_data,
  input  logic          multi,
  output logic          finish,
  output logic          err,
  output logic [AW-1:0] next_addr,
  output logic [AW-1:0] final_val
);

  localparam int LW = $clog2(MAX_LEVELS + 1);
  localparam logic [LW-1:0] LAST_LVL = LW'(MAX_LEVELS - 1);

  logic [LW-1:0] level_q;
  logic          last_flag;
  logic [AW-1:0] masked;

  assign last_flag = rsp_data[AW-1];
  assign masked    = {1'b0, rsp_data[AW-2:0]};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      level_q <= '0;
    end else if (rsp_valid) begin
      level_q <= level_q + 1'b1;
    end
  end

  assign err       = rsp_valid && multi && !last_flag && (level_q == LAST_LVL);
  assign finish    = rsp_valid && (!multi || last_flag || (level_q == LAST_LVL));
  assign next_addr = masked;
  assign final_val = !multi ? rsp_data : (last_flag ? masked : '0);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level_q <= LW'(MAX_LEVELS)) else $error("level count beyond cap"); // R12

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int AW         = 16,
  parameter int NREGS      = 8,
  parameter int MAX_LEVELS = 8,
  localparam int RW        = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [RW-1:0] base_sel,
  input  logic [RW-1:0] idx_sel,
  input  logic [AW-1:0] disp,
  input  logic [1:0]    scale,
  input  logic [1:0]    osize,
  output logic [RW-1:0] rf_rd_a_idx,
  input  logic [AW-1:0] rf_rd_a_data,
  output logic [RW-1:0] rf_rd_b_idx,
  input  logic [AW-1:0] rf_rd_b_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_wr_idx,
  output logic [AW-1:0] rf_wr_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] done_value,
  output logic          done_err
);

  ea_state_e     state_q;
  logic [3:0]    mode_q;
  logic [RW-1:0] bsel_q;
  logic [RW-1:0] isel_q;
  logic [AW-1:0] disp_q;
  logic [1:0]    scale_q;
  logic [1:0]    size_q;

  logic [AW-1:0] c_addr;
  logic [AW-1:0] c_wb_val;
  logic          c_wb_en;
  logic          c_fetch;

  logic          ch_clear;
  logic          ch_rsp;
  logic          ch_multi;
  logic          ch_finish;
  logic          ch_err;
  logic [AW-1:0] ch_next;
  logic [AW-1:0] ch_value;

  assign rf_rd_a_idx = bsel_q;
  assign rf_rd_b_idx = isel_q;

  ea_addr_calc #(.AW(AW)) calc_i (
    .mode   (mode_q),
    .ra     (rf_rd_a_data),
    .rb     (rf_rd_b_data),
    .disp   (disp_q),
    .scale  (scale_q),
    .osize  (size_q),
    .addr   (c_addr),
    .wb_val (c_wb_val),
    .wb_en  (c_wb_en),
    .fetch  (c_fetch)
  );

  assign ch_clear = (state_q == S_CALC);
  assign ch_rsp   = (state_q == S_WAIT) && mem_rvalid;
  assign ch_multi = (mode_q == M_MIND);

  ea_ptr_chain #(.AW(AW), .MAX_LEVELS(MAX_LEVELS)) chain_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (ch_clear),
    .rsp_valid (ch_rsp),
    .rsp_data  (mem_rdata),
    .multi     (ch_multi),
    .finish    (ch_finish),
    .err       (ch_err),
    .next_addr (ch_next),
    .final_val (ch_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      mode_q     <= '0;
      bsel_q     <= '0;
      isel_q     <= '0;
      disp_q     <= '0;
      scale_q    <= '0;
      size_q     <= '0;
      done       <= 1'b0;
      done_err   <= 1'b0;
      done_value <= '0;
      rf_we      <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;
      rf_we    <= 1'b0;
      mem_req  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            mode_q  <= mode;
            bsel_q  <= base_sel;
            isel_q  <= idx_sel;
            disp_q  <= disp;
            scale_q <= scale;
            size_q  <= osize;
            state_q <= S_CALC;
          end
        end
        S_CALC: begin
          if (c_fetch) begin
            mem_req  <= 1'b1;
            mem_addr <= c_addr;
            state_q  <= S_WAIT;
          end else begin
            done       <= 1'b1;
            done_value <= c_addr;
            rf_we      <= c_wb_en;
            rf_wr_idx  <= bsel_q;
            rf_wr_data <= c_wb_val;
            state_q    <= S_IDLE;
          end
        end
        S_WAIT: begin
          if (mem_rvalid) begin
            if (ch_finish) begin
              done       <= 1'b1;
              done_value <= ch_value;
              done_err   <= ch_err;
              state_q    <= S_IDLE;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= ch_next;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R13

  AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> done) else $error("writeback outside done"); // R8

  AST_REQ_FETCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mode_q == M_DIND || mode_q == M_MIND)) else $error("request in non-fetch mode"); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT && !mem_rvalid) |=> !mem_req) else $error("request while waiting"); // R11

  AST_FOLLOW_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(state_q) == S_WAIT) |-> !mem_addr[AW-1]) else $error("unmasked follow-on address"); // R10

  AST_ERR_MULTI_ONLY: assert property (@(posedge clk) disable iff (rst)
    done_err |-> (done && mode_q == M_MIND)) else $error("error outside multi-level walk"); // R12

endmodule

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
  localparam int AW   = 16;
  localparam int NR   = 8;
  localparam int RW   = 3;
  localparam int MAXL = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [3:0]    op_mode = '0;
  logic [RW-1:0] op_base = '0;
  logic [RW-1:0] op_idx = '0;
  logic [AW-1:0] op_disp = '0;
  logic [1:0]    op_scale = '0;
  logic [1:0]    op_size = '0;
  logic [RW-1:0] rf_rd_a_idx, rf_rd_b_idx, rf_wr_idx;
  logic [AW-1:0] rf_rd_a_data, rf_rd_b_data, rf_wr_data;
  logic          rf_we, mem_req, done, done_err;
  logic [AW-1:0] mem_addr, done_value;
  logic          mem_rvalid = 1'b0;
  logic [AW-1:0] mem_rdata = '0;

  logic [AW-1:0] regs [NR];
  logic [AW-1:0] mem [256];
  logic          tb_we = 1'b0;
  logic [RW-1:0] tb_wi = '0;
  logic [AW-1:0] tb_wd = '0;

  int lat = 1;
  int nreq = 0;
  int ndone = 0;
  int tests = 0;
  int fails = 0;
  logic          pend = 1'b0;
  int            cnt = 0;
  logic [7:0]    paddr = '0;

  always #2 clk = ~clk;

  ea_gen #(.AW(AW), .NREGS(NR), .MAX_LEVELS(MAXL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(op_mode), .base_sel(op_base),
    .idx_sel(op_idx), .disp(op_disp), .scale(op_scale), .osize(op_size),
    .rf_rd_a_idx(rf_rd_a_idx), .rf_rd_a_data(rf_rd_a_data),
    .rf_rd_b_idx(rf_rd_b_idx), .rf_rd_b_data(rf_rd_b_data),
    .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .done_value(done_value), .done_err(done_err)
  );

  assign rf_rd_a_data = regs[rf_rd_a_idx];
  assign rf_rd_b_data = regs[rf_rd_b_idx];

  always @(posedge clk) begin
    if (rf_we) regs[rf_wr_idx] <= rf_wr_data;
    else if (tb_we) regs[tb_wi] <= tb_wd;
  end

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else if (mem_req) begin
      nreq  <= nreq + 1;
      pend  <= 1'b1;
      cnt   <= lat;
      paddr <= mem_addr[7:0];
    end else if (pend) begin
      if (cnt <= 1) begin
        pend       <= 1'b0;
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[paddr];
      end else begin
        cnt <= cnt - 1;
      end
    end
    if (done) ndone <= ndone + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_reg(input int r, input logic [AW-1:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_wi = RW'(r); tb_wd = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic run_op(input logic [3:0] m, input int b, input int ix, input logic [AW-1:0] d,
                        input int sc, input int sz, input bit inject,
                        output logic [AW-1:0] val, output logic err, output logic we,
                        output int wi, output logic [AW-1:0] wd,
                        output int cyc, output int reqs, output int dones);
    int r0, d0;
    @(negedge clk);
    op_mode = m; op_base = RW'(b); op_idx = RW'(ix); op_disp = d;
    op_scale = 2'(sc); op_size = 2'(sz); start = 1'b1;
    r0 = nreq; d0 = ndone;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (inject) begin
        start = (cyc == 2);
        if (cyc == 2) begin op_mode = 4'd0; op_disp = 16'hBEEF; end
      end
    end
    start = 1'b0;
    if (cyc >= 1000) chk("watchdog op timeout", 1, 0);
    val = done_value; err = done_err; we = rf_we; wi = int'(rf_wr_idx); wd = rf_wr_data;
    repeat (3) @(negedge clk);
    reqs = nreq - r0;
    dones = ndone - d0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] v, wd, e, old, stp, tgt;
    logic er, we;
    int wi, cyc, rq, dn;

    for (int a = 0; a < 256; a++) mem[a] = 16'(a * 16'h0101);
    for (int r = 0; r < NR; r++) regs[r] = 16'(16'h0F00 + r * 16'h1235);

    repeat (3) @(negedge clk);
    chk("R1 done in reset", done, 0);
    chk("R1 mem_req in reset", mem_req, 0);
    chk("R1 rf_we in reset", rf_we, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 done_err after reset", done_err, 0);

    // R2 immediate and undefined codes
    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 16; m = (m == 0) ? 13 : m + 1) begin
        e = 16'(16'h1357 * (k + 1) + m);
        run_op(4'(m), k, k + 1, e, k, k, 0, v, er, we, wi, wd, cyc, rq, dn);
        chk("R2 imm value", v, e);
        chk("R2 imm latency", cyc, 1);
        chk("R2 imm no request", rq, 0);
        chk("R2 imm no write", we, 0);
      end
    end

    // R3, R4 register-based simple modes
    for (int b = 0; b < NR; b++) begin
      run_op(4'd1, b, 0, 16'h00AA, 0, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
      chk("R3 register value", v, regs[b]);
      chk("R3 register no write", we, 0);
      chk("R2 register latency", cyc, 1);
      run_op(4'd2, b, 0, 16'(16'h0321 + b), 0, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
      chk("R4 absolute value", v, 16'(16'h0321 + b));
      run_op(4'd3, b, 0, 16'h7777, 0, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
      chk("R4 indirect value", v, regs[b]);
      chk("R4 indirect no request", rq, 0);
    end

    // R5 indexed, scaled, combined
    for (int b = 0; b < NR; b++) begin
      for (int ix = 0; ix < NR; ix++) begin
        for (int sc = 0; sc < 4; sc++) begin
          e = 16'(16'h0040 * (b + 1) + sc);
          run_op(4'd4, b, ix, e, sc, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
          chk("R5 indexed", v, 16'(regs[b] + e));
          run_op(4'd5, b, ix, e, sc, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
          chk("R5 scaled", v, 16'((regs[ix] << sc) + e));
          run_op(4'd6, b, ix, e, sc, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
          chk("R5 combined", v, 16'((regs[ix] << sc) + regs[b] + e));
          chk("R8 combined no write", we, 0);
        end
      end
    end

    // R6, R7, R8 auto-modify modes
    for (int b = 0; b < NR; b++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int m = 7; m <= 10; m++) begin
          old = regs[b];
          stp = 16'(1 << sz);
          e = (m == 7 || m == 9) ? 16'(old + stp) : 16'(old - stp);
          run_op(4'(m), b, 0, 16'h0, 0, sz, 0, v, er, we, wi, wd, cyc, rq, dn);
          if (m <= 8) chk("R6 pre-modify address", v, e);
          else        chk("R7 post-modify address", v, old);
          chk("R8 write strobe", we, 1);
          chk("R8 write index", wi, b);
          chk("R7 written value", wd, e);
          run_op(4'd1, b, 0, 16'h0, 0, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
          chk("R8 register updated", v, e);
        end
      end
    end
    set_reg(5, 16'h0000);
    run_op(4'd8, 5, 0, 16'h0, 0, 3, 0, v, er, we, wi, wd, cyc, rq, dn);
    chk("R6 pre-decrement wrap", v, 16'hFFF8);

    // R9 double indirect
    mem[8'h20] = 16'h9234;
    set_reg(2, 16'h0020);
    run_op(4'd11, 2, 0, 16'h0, 0, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
    chk("R9 double indirect value", v, 16'h9234);
    chk("R9 double indirect one read", rq, 1);
    chk("R9 double indirect no error", er, 0);

    // R10, R11 multi-level walks
    for (int l = 1; l <= 3; l++) begin
      for (int n = 1; n <= MAXL; n++) begin
        lat = l;
        tgt = 16'(16'h0A00 + n * 16 + l);
        for (int i = 0; i < n; i++)
          mem[8'h40 + i] = (i == n - 1) ? (16'h8000 | tgt) : 16'(16'h40 + i + 1);
        set_reg(3, 16'h0040);
        run_op(4'd12, 3, 0, 16'h0, 0, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
        chk("R10 chain value", v, tgt);
        chk("R10 chain reads", rq, n);
        chk("R11 chain latency", cyc, 1 + n * (l + 2));
        chk("R12 no error at or below cap", er, 0);
      end
    end

    // R12 cap exceeded
    lat = 2;
    for (int i = 0; i < 9; i++) mem[8'h80 + i] = 16'(16'h80 + i + 1);
    set_reg(4, 16'h0080);
    run_op(4'd12, 4, 0, 16'h0, 0, 0, 0, v, er, we, wi, wd, cyc, rq, dn);
    chk("R12 error flag", er, 1);
    chk("R12 error value", v, 0);
    chk("R12 read count at cap", rq, MAXL);

    // R13 start ignored while busy
    lat = 6;
    mem[8'h40] = 16'h0041;
    mem[8'h41] = 16'h8ACE;
    set_reg(3, 16'h0040);
    run_op(4'd12, 3, 0, 16'h0, 0, 0, 1, v, er, we, wi, wd, cyc, rq, dn);
    chk("R13 value unaffected", v, 16'h0ACE);
    chk("R13 single done", dn, 1);
    chk("R13 latency unaffected", cyc, 1 + 2 * 8);
    chk("R13 reads unaffected", rq, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule